// File: doc/BRIEF.md
# Flash Geometry Query Reader

This block walks the parameter table of a flash array built from two 16-bit devices that share one 32-bit bus. After a start pulse it masters the bus on its own. Each table byte is fetched in a short session of its own: a query-mode entry command, a read of the wanted word index, and a query-mode exit command. The commands are mirrored into both halves of the bus word so that both devices see them. The three signature bytes are checked first. If they are good, the block decodes the command-set identifier, the total array size, the write-buffer size, the number of erase regions, and the layout of every region. Because two devices sit side by side, each size field comes out twice what one device reports.

Results are held in registers after a done pulse. A select input chooses one region, and the block returns that region's block size, block count, start address and end address. Software or a boot sequencer uses these values to find erase boundaries.

The byte sequencer has states SQ_IDLE, SQ_ENTER, SQ_ADDR, SQ_CAPT and SQ_EXIT. It moves SQ_IDLE→SQ_ENTER when a byte is requested, then moves unconditionally SQ_ENTER→SQ_ADDR→SQ_CAPT→SQ_EXIT→SQ_IDLE. The controller has states C_IDLE, C_SIG, C_ALG, C_SIZE, C_WBUF, C_NREG, C_REGION, C_DONE and C_FAIL. Its transitions are:
- C_IDLE→C_SIG on start.
- C_SIG stays in C_SIG while signature bytes match, goes to C_ALG after the third match, and goes to C_FAIL on a mismatch.
- C_ALG→C_SIZE→C_WBUF→C_NREG, each step taken as its byte arrives.
- C_NREG goes to C_DONE when the count is zero, and to C_REGION otherwise.
- C_REGION loops until the last byte of the last region, then goes to C_DONE.
- C_DONE→C_IDLE and C_FAIL→C_IDLE.

Top module: `cfi_geom_reader`

## Requirements
- R1: Each table byte is fetched in this order. First comes one write of 0x00980098 to word index 0x55. Next, the target word index is driven with the write strobe low for two cycles, and the byte is taken from the read data one cycle after the index first appears. Last comes one write of 0x00FF00FF to word index 0x55. The block issues no other writes.
- R2: The bytes at indices 0x10, 0x11 and 0x12 must be 0x51, 0x52 and 0x59. On the first mismatch the block fetches nothing more, pulses done with err high, and holds err until the next start.
- R3: alg_id equals the byte at index 0x13.
- R4: total_size equals 2^(b+1), where b is the byte at index 0x27. wbuf_size equals 2^(c+1), where c is the byte at index 0x2A.
- R5: rgn_count equals the byte at index 0x2C, clamped to MAX_RGN (default 32). Regions beyond the clamp are never fetched, and a count of zero ends the query right after that byte.
- R6: The 32-bit descriptor of region q is assembled little-endian from indices 0x2D+4q through 0x30+4q, with one byte per fetch.
- R7: The block size of a region is 512 times descriptor bits [31:16]. Its block count is descriptor bits [15:0] plus one.
- R8: Region 0 starts at address 0. Each region ends at its start plus block size times block count (modulo 2^32), and the next region starts where the previous one ends.
- R9: done is high for exactly one cycle, after the last region has been decoded. busy is high from the cycle after start until that done cycle and is low afterwards.
- R10: A start pulse while busy is ignored. The query in progress is not restarted and produces exactly one done.
- R11: Bits [31:8] of the read data have no effect on any result.
- R12: After reset, busy, done, err and bus_wr are low, and alg_id, total_size, wbuf_size and rgn_count are zero.
- R13: A start clears alg_id, total_size, wbuf_size, rgn_count and err. After a signature failure those fields read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a query when idle |
| busy | output | 1 | Query in progress |
| done | output | 1 | One-cycle end-of-query pulse |
| err | output | 1 | Signature mismatch, held until next start |
| bus_addr | output | AW | Word index driven to the flash pair |
| bus_wdata | output | 32 | Command word |
| bus_wr | output | 1 | Write strobe; low means read |
| bus_rdata | input | 32 | Read data, valid the cycle after the index |
| alg_id | output | 8 | Command-set identifier |
| total_size | output | 32 | Array size in bytes |
| wbuf_size | output | 32 | Write-buffer size in bytes |
| rgn_count | output | CW | Number of decoded regions |
| rgn_sel | input | RSEL_W | Region to show on the region outputs |
| rgn_blk_size | output | 32 | Block size of the selected region |
| rgn_blk_count | output | 17 | Block count of the selected region |
| rgn_start | output | 32 | Start address of the selected region |
| rgn_end | output | 32 | End address (exclusive) of the selected region |

## Verification
The hardest case to reach is the clamp on the region count. The table has to claim more regions than the block can hold, and every clamped-off descriptor must go unfetched. The bench meets this by loading a count of 40 with 32 distinct descriptors. It then checks both the final region's end address and the exact number of query-mode entries on the bus. A signature failure on the middle byte is checked the same way: the entry count must stop at two.

// File: rtl/cfi_geom_pkg.sv
package cfi_geom_pkg;

    localparam logic [31:0] QRY_ENTER = 32'h0098_0098;
    localparam logic [31:0] QRY_EXIT  = 32'h00FF_00FF;
    localparam logic [7:0]  QRY_CMD_IDX = 8'h55;

    localparam logic [7:0] IDX_SIG0 = 8'h10;
    localparam logic [7:0] IDX_ALG  = 8'h13;
    localparam logic [7:0] IDX_SIZE = 8'h27;
    localparam logic [7:0] IDX_WBUF = 8'h2A;
    localparam logic [7:0] IDX_NREG = 8'h2C;
    localparam logic [7:0] IDX_RGN0 = 8'h2D;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_ENTER,
        SQ_ADDR,
        SQ_CAPT,
        SQ_EXIT
    } seq_state_t;

    typedef enum logic [3:0] {
        C_IDLE,
        C_SIG,
        C_ALG,
        C_SIZE,
        C_WBUF,
        C_NREG,
        C_REGION,
        C_DONE,
        C_FAIL
    } ctl_state_t;

    // expected signature character for position n of the three
    function automatic logic [7:0] sig_char(input logic [1:0] n);
        case (n)
            2'd0:    return 8'h51;
            2'd1:    return 8'h52;
            default: return 8'h59;
        endcase
    endfunction

    // two devices in parallel: size is 2^(e+1); zero once it leaves 32 bits
    function automatic logic [31:0] pow2_size(input logic [7:0] e);
        logic [8:0] sh;
        sh = {1'b0, e} + 9'd1;
        if (sh < 9'd32)
            return 32'd1 << sh;
        return 32'd0;
    endfunction

endpackage

// File: rtl/cfi_byte_seq.sv
module cfi_byte_seq
    import cfi_geom_pkg::*;
#(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic [AW-1:0] idx,
    output logic          ack,
    output logic [7:0]    rd_byte,
    output logic [AW-1:0] bus_addr,
    output logic [31:0]   bus_wdata,
    output logic          bus_wr,
    input  logic [7:0]    bus_rbyte
);

    localparam logic [AW-1:0] CMD_IDX = AW'(QRY_CMD_IDX);

    seq_state_t state_q, state_d;
    logic [AW-1:0] idx_q;
    logic [7:0]    byte_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= SQ_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SQ_IDLE:  if (req) state_d = SQ_ENTER;
            SQ_ENTER: state_d = SQ_ADDR;
            SQ_ADDR:  state_d = SQ_CAPT;
            SQ_CAPT:  state_d = SQ_EXIT;
            SQ_EXIT:  state_d = SQ_IDLE;
            default:  state_d = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q  <= '0;
            byte_q <= '0;
        end else begin
            if (state_q == SQ_IDLE && req)
                idx_q <= idx;
            if (state_q == SQ_CAPT)
                byte_q <= bus_rbyte;
        end
    end

    always_comb begin
        bus_wr    = 1'b0;
        bus_wdata = '0;
        bus_addr  = idx_q;
        ack       = 1'b0;
        unique case (state_q)
            SQ_ENTER: begin
                bus_wr    = 1'b1;
                bus_wdata = QRY_ENTER;
                bus_addr  = CMD_IDX;
            end
            SQ_EXIT: begin
                bus_wr    = 1'b1;
                bus_wdata = QRY_EXIT;
                bus_addr  = CMD_IDX;
                ack       = 1'b1;
            end
            default: begin
                bus_wr = 1'b0;
            end
        endcase
    end

    assign rd_byte = byte_q;

endmodule

// File: rtl/cfi_rgn_table.sv
module cfi_rgn_table #(
    parameter int MAX_RGN = 32,
    parameter int RSEL_W  = (MAX_RGN > 1) ? $clog2(MAX_RGN) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [RSEL_W-1:0] wr_sel,
    input  logic [31:0]       wr_desc,
    input  logic [31:0]       wr_start,
    output logic [31:0]       nxt_end,
    input  logic [RSEL_W-1:0] rd_sel,
    output logic [31:0]       rd_blk_size,
    output logic [16:0]       rd_blk_cnt,
    output logic [31:0]       rd_start,
    output logic [31:0]       rd_end
);

    logic [31:0] new_size;
    logic [16:0] new_cnt;
    logic [31:0] prod;

    // block size is 512 times the upper half; count is lower half plus one
    assign new_size = {7'd0, wr_desc[31:16], 9'd0};
    assign new_cnt  = {1'b0, wr_desc[15:0]} + 17'd1;
    assign prod     = new_size * {15'd0, new_cnt};
    assign nxt_end  = wr_start + prod;

    logic [31:0] size_a  [MAX_RGN];
    logic [16:0] cnt_a   [MAX_RGN];
    logic [31:0] start_a [MAX_RGN];
    logic [31:0] end_a   [MAX_RGN];

    for (genvar g = 0; g < MAX_RGN; g++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                size_a[g]  <= '0;
                cnt_a[g]   <= '0;
                start_a[g] <= '0;
                end_a[g]   <= '0;
            end else if (we && (wr_sel == RSEL_W'(g))) begin
                size_a[g]  <= new_size;
                cnt_a[g]   <= new_cnt;
                start_a[g] <= wr_start;
                end_a[g]   <= nxt_end;
            end
        end
    end

    always_comb begin
        rd_blk_size = '0;
        rd_blk_cnt  = '0;
        rd_start    = '0;
        rd_end      = '0;
        if (int'(rd_sel) < MAX_RGN) begin
            rd_blk_size = size_a[rd_sel];
            rd_blk_cnt  = cnt_a[rd_sel];
            rd_start    = start_a[rd_sel];
            rd_end      = end_a[rd_sel];
        end
    end

endmodule

// File: rtl/cfi_geom_ctrl.sv
module cfi_geom_ctrl
    import cfi_geom_pkg::*;
#(
    parameter int AW      = 12,
    parameter int MAX_RGN = 32,
    parameter int RSEL_W  = (MAX_RGN > 1) ? $clog2(MAX_RGN) : 1,
    parameter int CW      = $clog2(MAX_RGN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic              req,
    output logic [AW-1:0]     idx,
    input  logic              ack,
    input  logic [7:0]        rd_byte,
    output logic [7:0]        alg_id,
    output logic [31:0]       total_size,
    output logic [31:0]       wbuf_size,
    output logic [CW-1:0]     rgn_count,
    output logic              tbl_we,
    output logic [RSEL_W-1:0] tbl_sel,
    output logic [31:0]       tbl_desc,
    output logic [31:0]       tbl_start,
    input  logic [31:0]       tbl_end
);

    localparam logic [7:0] CLAMP8 = 8'(MAX_RGN);

    ctl_state_t    state_q, state_d;
    logic [1:0]    bcnt_q;
    logic [RSEL_W-1:0] rgn_q;
    logic [23:0]   desc_lo_q;
    logic [31:0]   cursor_q;
    logic [CW-1:0] nreg_clamped;
    logic          sig_bad;
    logic          last_rgn;

    assign nreg_clamped = (rd_byte > CLAMP8) ? CW'(MAX_RGN) : CW'(rd_byte);
    assign sig_bad      = (rd_byte != sig_char(bcnt_q));
    assign last_rgn     = (CW'(rgn_q) + CW'(1)) == rgn_count;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= C_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            C_IDLE:   if (start) state_d = C_SIG;
            C_SIG:    if (ack) begin
                          if (sig_bad)
                              state_d = C_FAIL;
                          else if (bcnt_q == 2'd2)
                              state_d = C_ALG;
                      end
            C_ALG:    if (ack) state_d = C_SIZE;
            C_SIZE:   if (ack) state_d = C_WBUF;
            C_WBUF:   if (ack) state_d = C_NREG;
            C_NREG:   if (ack) state_d = (nreg_clamped == '0) ? C_DONE : C_REGION;
            C_REGION: if (ack && bcnt_q == 2'd3 && last_rgn) state_d = C_DONE;
            C_DONE:   state_d = C_IDLE;
            C_FAIL:   state_d = C_IDLE;
            default:  state_d = C_IDLE;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        req  = 1'b0;
        idx  = '0;
        done = 1'b0;
        busy = (state_q != C_IDLE);
        unique case (state_q)
            C_SIG: begin
                req = 1'b1;
                idx = AW'(IDX_SIG0) + AW'(bcnt_q);
            end
            C_ALG: begin
                req = 1'b1;
                idx = AW'(IDX_ALG);
            end
            C_SIZE: begin
                req = 1'b1;
                idx = AW'(IDX_SIZE);
            end
            C_WBUF: begin
                req = 1'b1;
                idx = AW'(IDX_WBUF);
            end
            C_NREG: begin
                req = 1'b1;
                idx = AW'(IDX_NREG);
            end
            C_REGION: begin
                req = 1'b1;
                idx = AW'(IDX_RGN0) + (AW'(rgn_q) << 2) + AW'(bcnt_q);
            end
            C_DONE, C_FAIL: done = 1'b1;
            default: req = 1'b0;
        endcase
    end

    assign tbl_we    = (state_q == C_REGION) && ack && (bcnt_q == 2'd3);
    assign tbl_sel   = rgn_q;
    assign tbl_desc  = {rd_byte, desc_lo_q};
    assign tbl_start = cursor_q;

    // result and progress registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bcnt_q     <= '0;
            rgn_q      <= '0;
            desc_lo_q  <= '0;
            cursor_q   <= '0;
            alg_id     <= '0;
            total_size <= '0;
            wbuf_size  <= '0;
            rgn_count  <= '0;
            err        <= 1'b0;
        end else begin
            unique case (state_q)
                C_IDLE: if (start) begin
                    bcnt_q     <= '0;
                    rgn_q      <= '0;
                    desc_lo_q  <= '0;
                    cursor_q   <= '0;
                    alg_id     <= '0;
                    total_size <= '0;
                    wbuf_size  <= '0;
                    rgn_count  <= '0;
                    err        <= 1'b0;
                end
                C_SIG: if (ack) begin
                    if (sig_bad)
                        err <= 1'b1;
                    else
                        bcnt_q <= (bcnt_q == 2'd2) ? 2'd0 : bcnt_q + 2'd1;
                end
                C_ALG:  if (ack) alg_id     <= rd_byte;
                C_SIZE: if (ack) total_size <= pow2_size(rd_byte);
                C_WBUF: if (ack) wbuf_size  <= pow2_size(rd_byte);
                C_NREG: if (ack) begin
                    rgn_count <= nreg_clamped;
                    bcnt_q    <= '0;
                end
                C_REGION: if (ack) begin
                    unique case (bcnt_q)
                        2'd0: desc_lo_q[7:0]   <= rd_byte;
                        2'd1: desc_lo_q[15:8]  <= rd_byte;
                        2'd2: desc_lo_q[23:16] <= rd_byte;
                        default: begin
                            cursor_q <= tbl_end;
                            rgn_q    <= rgn_q + RSEL_W'(1);
                        end
                    endcase
                    bcnt_q <= bcnt_q + 2'd1;
                end
                default: begin
                    bcnt_q <= bcnt_q;
                end
            endcase
        end
    end

endmodule

// File: rtl/cfi_geom_reader.sv
module cfi_geom_reader #(
    parameter int AW      = 12,
    parameter int MAX_RGN = 32,
    parameter int RSEL_W  = (MAX_RGN > 1) ? $clog2(MAX_RGN) : 1,
    parameter int CW      = $clog2(MAX_RGN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [AW-1:0]     bus_addr,
    output logic [31:0]       bus_wdata,
    output logic              bus_wr,
    input  logic [31:0]       bus_rdata,
    output logic [7:0]        alg_id,
    output logic [31:0]       total_size,
    output logic [31:0]       wbuf_size,
    output logic [CW-1:0]     rgn_count,
    input  logic [RSEL_W-1:0] rgn_sel,
    output logic [31:0]       rgn_blk_size,
    output logic [16:0]       rgn_blk_count,
    output logic [31:0]       rgn_start,
    output logic [31:0]       rgn_end
);

    logic              req;
    logic [AW-1:0]     idx;
    logic              ack;
    logic [7:0]        rd_byte;
    logic              tbl_we;
    logic [RSEL_W-1:0] tbl_sel;
    logic [31:0]       tbl_desc;
    logic [31:0]       tbl_start;
    logic [31:0]       tbl_end;
    logic              unused_rdata_hi;

    // only the low byte lane carries table data
    assign unused_rdata_hi = ^bus_rdata[31:8];

    cfi_byte_seq #(.AW(AW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .idx       (idx),
        .ack       (ack),
        .rd_byte   (rd_byte),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_wr    (bus_wr),
        .bus_rbyte (bus_rdata[7:0])
    );

    cfi_geom_ctrl #(
        .AW      (AW),
        .MAX_RGN (MAX_RGN),
        .RSEL_W  (RSEL_W),
        .CW      (CW)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .busy       (busy),
        .done       (done),
        .err        (err),
        .req        (req),
        .idx        (idx),
        .ack        (ack),
        .rd_byte    (rd_byte),
        .alg_id     (alg_id),
        .total_size (total_size),
        .wbuf_size  (wbuf_size),
        .rgn_count  (rgn_count),
        .tbl_we     (tbl_we),
        .tbl_sel    (tbl_sel),
        .tbl_desc   (tbl_desc),
        .tbl_start  (tbl_start),
        .tbl_end    (tbl_end)
    );

    cfi_rgn_table #(
        .MAX_RGN (MAX_RGN),
        .RSEL_W  (RSEL_W)
    ) u_tbl (
        .clk         (clk),
        .rst_n       (rst_n),
        .we          (tbl_we),
        .wr_sel      (tbl_sel),
        .wr_desc     (tbl_desc),
        .wr_start    (tbl_start),
        .nxt_end     (tbl_end),
        .rd_sel      (rgn_sel),
        .rd_blk_size (rgn_blk_size),
        .rd_blk_cnt  (rgn_blk_count),
        .rd_start    (rgn_start),
        .rd_end      (rgn_end)
    );

endmodule

// File: rtl/cfi_geom_sva.sv
module cfi_geom_sva
    import cfi_geom_pkg::*;
#(
    parameter int AW      = 12,
    parameter int MAX_RGN = 32,
    parameter int CW      = $clog2(MAX_RGN + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          done,
    input logic          err,
    input logic [AW-1:0] bus_addr,
    input logic [31:0]   bus_wdata,
    input logic          bus_wr,
    input logic [CW-1:0] rgn_count
);

    a_r1_cmd_writes_only: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |-> (bus_addr == AW'(QRY_CMD_IDX)) &&
                   (bus_wdata == QRY_ENTER || bus_wdata == QRY_EXIT));

    a_r1_exit_after_held_read: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_wdata == QRY_EXIT) |->
            !$past(bus_wr) && !$past(bus_wr, 2) &&
            ($past(bus_addr) == $past(bus_addr, 2)) &&
            $past(bus_wr, 3) && ($past(bus_wdata, 3) == QRY_ENTER));

    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r9_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    a_r2_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> done);

    a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        rgn_count <= CW'(MAX_RGN));

    a_r10_no_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

endmodule

bind cfi_geom_reader cfi_geom_sva #(
    .AW      (AW),
    .MAX_RGN (MAX_RGN),
    .CW      (CW)
) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .err       (err),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_wr    (bus_wr),
    .rgn_count (rgn_count)
);

// File: tb/cfi_geom_reader_tb.sv
module cfi_geom_reader_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 12;
    localparam int MAX_RGN = 32;
    localparam int RSEL_W = 5;
    localparam int CW = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic              busy, done, err;
    logic [AW-1:0]     bus_addr;
    logic [31:0]       bus_wdata;
    logic              bus_wr;
    logic [31:0]       bus_rdata = '0;
    logic [7:0]        alg_id;
    logic [31:0]       total_size, wbuf_size;
    logic [CW-1:0]     rgn_count;
    logic [RSEL_W-1:0] rgn_sel = '0;
    logic [31:0]       rgn_blk_size, rgn_start, rgn_end;
    logic [16:0]       rgn_blk_count;

    int n_checks = 0;
    int n_fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfi_geom_reader #(.AW(AW), .MAX_RGN(MAX_RGN)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .err(err),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rdata(bus_rdata),
        .alg_id(alg_id), .total_size(total_size), .wbuf_size(wbuf_size),
        .rgn_count(rgn_count), .rgn_sel(rgn_sel), .rgn_blk_size(rgn_blk_size),
        .rgn_blk_count(rgn_blk_count), .rgn_start(rgn_start), .rgn_end(rgn_end)
    );

    // flash pair model: table visible only in query mode, noise in upper lanes
    logic [7:0] rom [256];
    logic qmode = 1'b0;
    int   n_enter = 0;
    int   n_exit = 0;
    int   n_badwr = 0;
    logic [23:0] noise = 24'hA55AC3;

    always @(posedge clk) begin
        if (rst_n && bus_wr) begin
            if (bus_addr == 12'h055 && bus_wdata == 32'h0098_0098) begin
                qmode <= 1'b1;
                n_enter++;
            end else if (bus_addr == 12'h055 && bus_wdata == 32'h00FF_00FF) begin
                qmode <= 1'b0;
                n_exit++;
            end else begin
                n_badwr++;
            end
        end else begin
            bus_rdata <= qmode ? {noise, rom[bus_addr[7:0]]} : 32'h0000_0077;
            noise <= {noise[22:0], noise[23] ^ noise[18]};
        end
    end

    int n_done = 0;
    int n_wide = 0;
    logic done_prev = 1'b0;
    always @(negedge clk) begin
        if (done) n_done++;
        if (done && done_prev) n_wide++;
        done_prev <= done;
    end

    bit wd_fired = 1'b0;
    initial begin
        repeat (150000) @(posedge clk);
        wd_fired = 1'b1;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog R9: actual no finish, expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic clear_rom();
        for (int i = 0; i < 256; i++) rom[i] = 8'hEE;
        rom[8'h10] = 8'h51;
        rom[8'h11] = 8'h52;
        rom[8'h12] = 8'h59;
    endtask

    task automatic put_desc(input int q, input logic [15:0] sz16, input logic [15:0] cn16);
        rom[8'h2D + 4*q]     = cn16[7:0];
        rom[8'h2D + 4*q + 1] = cn16[15:8];
        rom[8'h2D + 4*q + 2] = sz16[7:0];
        rom[8'h2D + 4*q + 3] = sz16[15:8];
    endtask

    // returns cycles taken; counters cleared first
    task automatic run_query(output int cycles);
        n_enter = 0;
        n_exit = 0;
        n_badwr = 0;
        n_done = 0;
        cycles = 0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        while (!done && cycles < 5000) begin
            @(negedge clk);
            cycles++;
        end
        @(negedge clk);
    endtask

    task automatic chk_region(input string req, input int q, input longint bsz,
                              input longint bcnt, input longint st, input longint en);
        rgn_sel = RSEL_W'(q);
        #1;
        chk({req, " blk size"}, 64'(rgn_blk_size), 64'(bsz));
        chk({req, " blk count"}, 64'(rgn_blk_count), 64'(bcnt));
        chk({req, " start"}, 64'(rgn_start), 64'(st & 64'hFFFF_FFFF));
        chk({req, " end"}, 64'(rgn_end), 64'(en & 64'hFFFF_FFFF));
    endtask

    task automatic t_reset();
        chk("R12 busy", 64'(busy), 0);
        chk("R12 done", 64'(done), 0);
        chk("R12 err", 64'(err), 0);
        chk("R12 bus_wr", 64'(bus_wr), 0);
        chk("R12 alg_id", 64'(alg_id), 0);
        chk("R12 total_size", 64'(total_size), 0);
        chk("R12 wbuf_size", 64'(wbuf_size), 0);
        chk("R12 rgn_count", 64'(rgn_count), 0);
    endtask

    task automatic t_two_regions();
        int cyc;
        longint st;
        clear_rom();
        rom[8'h13] = 8'h01;
        rom[8'h27] = 8'h16;
        rom[8'h2A] = 8'h04;
        rom[8'h2C] = 8'h02;
        put_desc(0, 16'h0040, 16'h0003);
        put_desc(1, 16'h0100, 16'h003D);
        run_query(cyc);
        chk("R9 single done", 64'(n_done), 1);
        chk("R9 busy low after done", 64'(busy), 0);
        chk("R2 err clear", 64'(err), 0);
        chk("R1 entries", 64'(n_enter), 15);
        chk("R1 exits", 64'(n_exit), 15);
        chk("R1 stray writes", 64'(n_badwr), 0);
        chk("R3 alg_id", 64'(alg_id), 64'h01);
        chk("R4 total_size", 64'(total_size), 64'(1) << 23);
        chk("R4 wbuf_size", 64'(wbuf_size), 64'd32);
        chk("R5 rgn_count", 64'(rgn_count), 2);
        st = 0;
        chk_region("R6 R7 R8 r0", 0, 64'h40 * 512, 4, st, st + 64'h40 * 512 * 4);
        st = st + 64'h40 * 512 * 4;
        chk_region("R6 R7 R8 R11 r1", 1, 64'h100 * 512, 62, st, st + 64'h100 * 512 * 62);
    endtask

    task automatic t_sig_fail();
        int cyc;
        clear_rom();
        rom[8'h11] = 8'h58;
        rom[8'h13] = 8'h02;
        rom[8'h2C] = 8'h01;
        n_enter = 0;
        n_done = 0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        cyc = 0;
        while (!done && cyc < 5000) begin
            @(negedge clk);
            cyc++;
        end
        chk("R2 err with done", 64'(err), 1);
        repeat (30) @(negedge clk);
        chk("R2 fetches stop", 64'(n_enter), 2);
        chk("R2 err held", 64'(err), 1);
        chk("R2 one done", 64'(n_done), 1);
        chk("R13 alg cleared", 64'(alg_id), 0);
        chk("R13 size cleared", 64'(total_size), 0);
        chk("R13 count cleared", 64'(rgn_count), 0);
    endtask

    task automatic t_zero_regions();
        int cyc;
        clear_rom();
        rom[8'h13] = 8'h03;
        rom[8'h27] = 8'h14;
        rom[8'h2A] = 8'h00;
        rom[8'h2C] = 8'h00;
        run_query(cyc);
        chk("R2 err cleared by start", 64'(err), 0);
        chk("R5 zero count", 64'(rgn_count), 0);
        chk("R5 zero count fetches", 64'(n_enter), 7);
        chk("R4 smallest wbuf", 64'(wbuf_size), 2);
        chk("R4 size 2^21", 64'(total_size), 64'(1) << 21);
        chk("R3 alg 3", 64'(alg_id), 3);
    endtask

    task automatic t_clamp();
        int cyc;
        longint st;
        longint en;
        clear_rom();
        rom[8'h13] = 8'h01;
        rom[8'h27] = 8'h17;
        rom[8'h2A] = 8'h05;
        rom[8'h2C] = 8'd40;
        for (int q = 0; q < MAX_RGN; q++) put_desc(q, 16'h0001 + 16'(q % 3), 16'(q));
        run_query(cyc);
        chk("R5 clamped count", 64'(rgn_count), 32);
        chk("R5 clamped fetches", 64'(n_enter), 7 + 4 * 32);
        st = 0;
        for (int q = 0; q < MAX_RGN; q++) begin
            en = st + longint'(1 + q % 3) * 512 * longint'(q + 1);
            if (q == 0 || q == 17 || q == 31)
                chk_region("R8 chain", q, longint'(1 + q % 3) * 512, q + 1, st, en);
            st = en;
        end
    endtask

    task automatic t_restart_ignored();
        int cyc;
        clear_rom();
        rom[8'h13] = 8'h01;
        rom[8'h27] = 8'h10;
        rom[8'h2A] = 8'h03;
        rom[8'h2C] = 8'h01;
        put_desc(0, 16'h0008, 16'h00FF);
        n_enter = 0;
        n_done = 0;
        n_wide = 0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        repeat (22) @(negedge clk);
        start = 1'b1;
        @(negedge clk) start = 1'b0;
        cyc = 0;
        while (!done && cyc < 5000) begin
            @(negedge clk);
            cyc++;
        end
        repeat (40) @(negedge clk);
        chk("R10 one done", 64'(n_done), 1);
        chk("R10 no refetch", 64'(n_enter), 11);
        chk("R9 done width", 64'(n_wide), 0);
        chk("R10 idle after", 64'(busy), 0);
        chk_region("R7 R10 r0", 0, 8 * 512, 256, 0, 8 * 512 * 256);
    endtask

    initial begin
        clear_rom();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_two_regions();
        t_sig_fail();
        t_zero_regions();
        t_clamp();
        t_restart_ignored();
        if (!wd_fired) begin
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule